// File: doc/BRIEF.md
# Disk Write Data Formatter

This block prepares user data for the write head of a disk drive. On the byte side it accepts one controller byte per byte time with an even parity bit, while a write gate is high. It can replace a marker run of all-ones bytes with a generated equalizer training preamble and a sync byte. It scrambles only the bytes that follow the sync byte. The result is handed on to a run-length encoder, which is not part of this block.

On the serial side it takes the encoded code bits back, one per valid strobe, and passes them through a 1/(1⊕D²) precoder. It flags each written one that needs a late timing shift. Dropping the write gate returns both halves to their start state.

Top module: `write_formatter`

## Requirements
- R1: A byte accepted (byte_valid and wr_gate both high at a clock edge) appears on byte_out with byte_out_valid high after exactly one clock edge. Scrambled and unscrambled bytes take the same path delay. byte_out_valid is low after any edge that accepted no byte.
- R2: With auto_train low, bytes pass unchanged until an accepted byte equals 69H. That byte is the sync byte and is also output unchanged. Only the bytes after it are scrambled.
- R3: With auto_train high, every output byte before sync is 93H. An exception is the sixth consecutive accepted FFH, which is output as 69H and acts as the sync byte. A non-FFH byte restarts the count. In this mode, 1FH is never output before sync.
- R4: Parity is even over {byte_in, byte_par}. An accepted byte whose parity fails sets parity_err at the next edge. The flag stays high while wr_gate is high and clears at the first edge with wr_gate low. Bytes arriving with wr_gate low are not checked.
- R5: The scrambler state is reloaded with all ones on the sync byte. It advances 8 steps for each post-sync byte. The keystream is o(n)=1 for n<10 and o(n)=o(n-7)⊕o(n-10) otherwise. Post-sync byte j is XORed with o(8j)..o(8j+7), with o(8j) on bit 7.
- R6: With scram_en low, a post-sync byte is output unchanged. The keystream still advances for that byte, so re-enabling resumes at the mask of the current byte index.
- R7: While wr_gate is low, the byte side returns to the pre-sync state with its FFH count cleared. The next write needs a new sync byte.
- R8: A code bit x with code_valid and wr_gate high produces precoded bit y = x ⊕ y2. Here y2 is the precoded bit two valid bits earlier. y appears on pre_bit with pre_valid high one edge later.
- R9: While wr_gate is low, both precoder state bits are preset to 0. Code bits offered then are ignored, with pre_valid low and late_shift low.
- R10: late_shift is high with a precoded one whose preceding precoded bit (since the last preset) was also one. The first one of a run is never flagged, and late_shift is never high with a zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_gate | input | 1 | Write gate; low ends the write and presets state |
| auto_train | input | 1 | Generate preamble and sync from an FFH run |
| scram_en | input | 1 | Scramble post-sync bytes |
| byte_valid | input | 1 | A byte is offered this cycle |
| byte_in | input | 8 | Controller data byte |
| byte_par | input | 1 | Even parity bit for byte_in |
| byte_out | output | 8 | Formatted byte to the encoder |
| byte_out_valid | output | 1 | byte_out holds a new byte |
| parity_err | output | 1 | Sticky parity error for this write |
| code_valid | input | 1 | A code bit is offered this cycle |
| code_bit | input | 1 | Encoded serial bit |
| pre_bit | output | 1 | Precoded write bit |
| pre_valid | output | 1 | pre_bit holds a new bit |
| late_shift | output | 1 | Write this one late |

## Verification
Two pairs of functions can land on the same clock edge. The sixth FFH can carry bad parity, so the sync byte 69H and the rising parity_err come from one edge. The bench checks both on that edge and confirms that the byte after it is still scrambled from the fresh all-ones seed. The write gate can also fall in the same cycle as a valid code bit. Here the preset must win: the bench expects no pre_valid after that edge. The first one after the gate reopens must come out unflagged, as if no earlier bits existed.

// File: rtl/wfmt_pkg.sv
`timescale 1ns/1ps
package wfmt_pkg;
  localparam int SCR_W   = 10;
  localparam int SCR_TAP = 7;
  localparam int BYTE_W  = 8;

  typedef enum logic {PH_PRE = 1'b0, PH_DATA = 1'b1} phase_e;

  // One LFSR step: shift left, feedback from the top bit and the tap.
  function automatic logic [SCR_W-1:0] scr_step(input logic [SCR_W-1:0] s);
    return {s[SCR_W-2:0], s[SCR_W-1] ^ s[SCR_TAP-1]};
  endfunction

  // Keystream mask for one byte: first step lands on the MSB.
  function automatic logic [BYTE_W-1:0] scr_mask(input logic [SCR_W-1:0] s);
    logic [SCR_W-1:0]  st;
    logic [BYTE_W-1:0] m;
    st = s;
    m  = '0;
    for (int k = 0; k < BYTE_W; k++) begin
      m[BYTE_W-1-k] = st[SCR_W-1];
      st = scr_step(st);
    end
    return m;
  endfunction

  function automatic logic [SCR_W-1:0] scr_advance(input logic [SCR_W-1:0] s);
    logic [SCR_W-1:0] st;
    st = s;
    for (int k = 0; k < BYTE_W; k++) st = scr_step(st);
    return st;
  endfunction

  function automatic logic parity_ok(input logic [BYTE_W-1:0] b, input logic p);
    return ((^b) ^ p) == 1'b0;
  endfunction
endpackage

// File: rtl/wfmt_byte_ctrl.sv
`timescale 1ns/1ps
module wfmt_byte_ctrl
  import wfmt_pkg::*;
#(
  parameter int             TRAIN_RUN = 6,
  parameter logic [7:0]     MARK_BYTE = 8'hFF,
  parameter logic [7:0]     PRE_BYTE  = 8'h93,
  parameter logic [7:0]     SYNC_BYTE = 8'h69
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate,
  input  logic       accept,
  input  logic       auto_en,
  input  logic [7:0] byte_in,
  output logic [7:0] emit,
  output logic       sync_evt,
  output logic       step_evt
);
  localparam int RUN_W = $clog2(TRAIN_RUN + 1);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(TRAIN_RUN - 1);

  phase_e           ph_q, ph_d;
  logic [RUN_W-1:0] run_q, run_d;

  always_comb begin
    ph_d     = ph_q;
    run_d    = run_q;
    emit     = byte_in;
    sync_evt = 1'b0;
    step_evt = 1'b0;
    if (!gate) begin
      ph_d  = PH_PRE;
      run_d = '0;
    end else if (accept) begin
      if (ph_q == PH_PRE) begin
        if (auto_en) begin
          emit = PRE_BYTE;
          if (byte_in == MARK_BYTE) begin
            if (run_q == RUN_LAST) begin
              emit     = SYNC_BYTE;
              sync_evt = 1'b1;
              run_d    = '0;
              ph_d     = PH_DATA;
            end else begin
              run_d = run_q + 1'b1;
            end
          end else begin
            run_d = '0;
          end
        end else if (byte_in == SYNC_BYTE) begin
          sync_evt = 1'b1;
          ph_d     = PH_DATA;
        end
      end else begin
        step_evt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_PRE;
      run_q <= '0;
    end else begin
      ph_q  <= ph_d;
      run_q <= run_d;
    end
  end

  // R2: a sync byte is never followed directly by another sync event
  p_sync_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_evt |=> !sync_evt);
  // R3: the marker count never passes the last run position
  p_run_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_LAST);
  // R7: a closed gate leaves the pre-sync phase with no count
  p_gate_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (ph_q == PH_PRE && run_q == '0));
endmodule

// File: rtl/wfmt_parity.sv
`timescale 1ns/1ps
module wfmt_parity
  import wfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       gate,
  input  logic       accept,
  input  logic [7:0] byte_in,
  input  logic       par_in,
  output logic       par_err
);
  logic bad_evt;
  assign bad_evt = accept && !parity_ok(byte_in, par_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       par_err <= 1'b0;
    else if (!gate)   par_err <= 1'b0;
    else if (bad_evt) par_err <= 1'b1;
  end

  // R4: sticky while the gate stays open
  p_perr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (par_err && gate) |=> par_err);
  // R4: cleared once the gate closes
  p_perr_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> !par_err);
  // R4: a bad byte always raises the flag
  p_perr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bad_evt |=> par_err);
endmodule

// File: rtl/wfmt_scrambler.sv
`timescale 1ns/1ps
module wfmt_scrambler
  import wfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       seed,
  input  logic       step,
  output logic [7:0] mask
);
  logic [SCR_W-1:0] st_q;

  assign mask = scr_mask(st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    st_q <= '1;
    else if (seed) st_q <= '1;
    else if (step) st_q <= scr_advance(st_q);
  end

  // R5: the state is all ones right after a sync byte
  p_seed_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> (st_q == {SCR_W{1'b1}}));
  // R5: the state does not move without a post-sync byte
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed && !step) |=> $stable(st_q));
  // R5: a maximal LFSR never reaches the all-zero lockup state
  p_no_lockup_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
endmodule

// File: rtl/wfmt_precoder.sv
`timescale 1ns/1ps
module wfmt_precoder (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  input  logic bit_valid,
  input  logic bit_in,
  output logic pre_bit,
  output logic pre_valid,
  output logic late
);
  logic d1_q, d2_q;
  logic take, y;

  assign take = gate && bit_valid;
  assign y    = bit_in ^ d2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1_q <= 1'b0; d2_q <= 1'b0;
      pre_bit <= 1'b0; pre_valid <= 1'b0; late <= 1'b0;
    end else if (!gate) begin
      d1_q <= 1'b0; d2_q <= 1'b0;
      pre_bit <= 1'b0; pre_valid <= 1'b0; late <= 1'b0;
    end else if (take) begin
      d2_q      <= d1_q;
      d1_q      <= y;
      pre_bit   <= y;
      pre_valid <= 1'b1;
      late      <= y & d1_q;
    end else begin
      pre_valid <= 1'b0;
      late      <= 1'b0;
    end
  end

  // R9: no output bit after a closed gate
  p_preset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (!pre_valid && !late));
  // R10: late shift only ever marks a written one
  p_late_on_one_r10: assert property (@(posedge clk) disable iff (!rst_n)
    late |-> (pre_bit && pre_valid));
  // R8: every accepted bit yields exactly one output strobe
  p_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> pre_valid);
endmodule

// File: rtl/write_formatter.sv
`timescale 1ns/1ps
module write_formatter
  import wfmt_pkg::*;
#(
  parameter int TRAIN_RUN = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_gate,
  input  logic       auto_train,
  input  logic       scram_en,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  input  logic       byte_par,
  output logic [7:0] byte_out,
  output logic       byte_out_valid,
  output logic       parity_err,
  input  logic       code_valid,
  input  logic       code_bit,
  output logic       pre_bit,
  output logic       pre_valid,
  output logic       late_shift
);
  logic       accept;
  logic [7:0] emit, mask, out_d;
  logic       sync_evt, step_evt;

  assign accept = byte_valid && wr_gate;

  wfmt_byte_ctrl #(.TRAIN_RUN(TRAIN_RUN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .gate(wr_gate), .accept(accept),
    .auto_en(auto_train), .byte_in(byte_in),
    .emit(emit), .sync_evt(sync_evt), .step_evt(step_evt));

  wfmt_parity u_par (
    .clk(clk), .rst_n(rst_n), .gate(wr_gate), .accept(accept),
    .byte_in(byte_in), .par_in(byte_par), .par_err(parity_err));

  wfmt_scrambler u_scr (
    .clk(clk), .rst_n(rst_n), .seed(sync_evt), .step(step_evt), .mask(mask));

  wfmt_precoder u_pre (
    .clk(clk), .rst_n(rst_n), .gate(wr_gate), .bit_valid(code_valid),
    .bit_in(code_bit), .pre_bit(pre_bit), .pre_valid(pre_valid),
    .late(late_shift));

  // Mask is applied in the same stage as the plain path: no extra latency.
  assign out_d = emit ^ ((step_evt && scram_en) ? mask : 8'h00);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_out       <= 8'h00;
      byte_out_valid <= 1'b0;
    end else begin
      byte_out_valid <= accept;
      if (accept) byte_out <= out_d;
    end
  end

  // R1: accepted byte shows up after one edge
  p_out_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> byte_out_valid);
  // R1: no strobe without an accepted byte
  p_out_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> !byte_out_valid);
  // R6: with scrambling off the data byte passes untouched
  p_plain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !scram_en) |=> (byte_out == $past(byte_in)));
endmodule

// File: tb/sim_write_formatter.sv
`timescale 1ns/1ps
module sim_write_formatter;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_gate = 1'b0, auto_train = 1'b0, scram_en = 1'b0;
  logic       byte_valid = 1'b0, byte_par = 1'b0;
  logic [7:0] byte_in = 8'h00;
  logic [7:0] byte_out;
  logic       byte_out_valid, parity_err;
  logic       code_valid = 1'b0, code_bit = 1'b0;
  logic       pre_bit, pre_valid, late_shift;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  bit ks [0:1023];
  bit y1 = 1'b0, y2 = 1'b0;

  always #5 clk = ~clk;

  write_formatter u0 (
    .clk(clk), .rst_n(rst_n), .wr_gate(wr_gate), .auto_train(auto_train),
    .scram_en(scram_en), .byte_valid(byte_valid), .byte_in(byte_in),
    .byte_par(byte_par), .byte_out(byte_out), .byte_out_valid(byte_out_valid),
    .parity_err(parity_err), .code_valid(code_valid), .code_bit(code_bit),
    .pre_bit(pre_bit), .pre_valid(pre_valid), .late_shift(late_shift));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ks_byte(input int j);
    logic [7:0] m;
    for (int k = 0; k < 8; k++) m[7-k] = ks[8*j + k];
    return m;
  endfunction

  task automatic put_byte(input logic [7:0] b, input bit bad);
    @(negedge clk);
    byte_valid = 1'b1; byte_in = b; byte_par = (^b) ^ bad; code_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic idle;
    @(negedge clk);
    byte_valid = 1'b0; code_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  task automatic set_gate(input logic g);
    @(negedge clk);
    wr_gate = g; byte_valid = 1'b0; code_valid = 1'b0;
    if (!g) begin y1 = 1'b0; y2 = 1'b0; end
    @(posedge clk); #1;
  endtask

  // Offers one code bit and checks the precoded result against the model.
  task automatic put_bit(input logic x, input string tag);
    logic y, lt;
    @(negedge clk);
    code_valid = 1'b1; code_bit = x; byte_valid = 1'b0;
    @(posedge clk); #1;
    y  = x ^ y2;
    lt = y & y1;
    y2 = y1; y1 = y;
    chk({tag, " R8 valid"}, pre_valid, 1);
    chk({tag, " R8 bit"}, pre_bit, y);
    chk({tag, " R10 late"}, late_shift, lt);
  endtask

  task automatic t_reset;
    chk("R1 reset valid", byte_out_valid, 0);
    chk("R4 reset perr", parity_err, 0);
    chk("R9 reset pre_valid", pre_valid, 0);
    chk("R10 reset late", late_shift, 0);
  endtask

  task automatic t_auto;
    set_gate(1'b0); auto_train = 1'b1; scram_en = 1'b1; set_gate(1'b1);
    put_byte(8'hAA, 0); chk("R3 non-marker", byte_out, 8'h93);
    chk("R1 strobe", byte_out_valid, 1);
    put_byte(8'h1F, 0); chk("R3 never 1F", byte_out, 8'h93);
    for (int i = 0; i < 3; i++) begin put_byte(8'hFF, 0); chk("R3 early FF", byte_out, 8'h93); end
    put_byte(8'h00, 0); chk("R3 restart", byte_out, 8'h93);
    for (int i = 0; i < 5; i++) begin put_byte(8'hFF, 0); chk("R3 preamble", byte_out, 8'h93); end
    put_byte(8'hFF, 0); chk("R3 sync", byte_out, 8'h69);
    put_byte(8'h12, 0); chk("R5 first", byte_out, 8'h12 ^ ks_byte(0));
    idle(); chk("R1 no strobe", byte_out_valid, 0);
    put_byte(8'h34, 0); chk("R5 second", byte_out, 8'h34 ^ ks_byte(1));
    put_byte(8'hFF, 0); chk("R3 no resync", byte_out, 8'hFF ^ ks_byte(2));
  endtask

  task automatic t_manual;
    set_gate(1'b0); auto_train = 1'b0; scram_en = 1'b1; set_gate(1'b1);
    put_byte(8'h11, 0); chk("R2 pass", byte_out, 8'h11);
    put_byte(8'hFF, 0); chk("R2 pass FF", byte_out, 8'hFF);
    put_byte(8'h69, 0); chk("R2 sync plain", byte_out, 8'h69);
    put_byte(8'h69, 0); chk("R2 after sync", byte_out, 8'h69 ^ ks_byte(0));
    scram_en = 1'b0;
    put_byte(8'h5A, 0); chk("R6 off", byte_out, 8'h5A);
    scram_en = 1'b1;
    put_byte(8'hC3, 0); chk("R6 resume", byte_out, 8'hC3 ^ ks_byte(2));
    set_gate(1'b0); set_gate(1'b1);
    put_byte(8'h77, 0); chk("R7 new write", byte_out, 8'h77);
    put_byte(8'h69, 0); chk("R7 sync again", byte_out, 8'h69);
    put_byte(8'h00, 0); chk("R7 reseed", byte_out, ks_byte(0));
  endtask

  task automatic t_parity;
    set_gate(1'b0);
    put_byte(8'h01, 1); chk("R4 gate low ignored", parity_err, 0);
    chk("R1 gate low no strobe", byte_out_valid, 0);
    set_gate(1'b1);
    put_byte(8'h3C, 0); chk("R4 good", parity_err, 0);
    put_byte(8'h3D, 1); chk("R4 set", parity_err, 1);
    put_byte(8'h3D, 0); chk("R4 sticky", parity_err, 1);
    idle(); chk("R4 sticky idle", parity_err, 1);
    set_gate(1'b0); chk("R4 clear", parity_err, 0);
  endtask

  task automatic t_precode;
    set_gate(1'b0); set_gate(1'b1);
    put_bit(1, "seq"); put_bit(0, "seq"); put_bit(1, "seq"); put_bit(1, "seq");
    put_bit(0, "seq"); put_bit(0, "seq"); put_bit(1, "seq"); put_bit(1, "seq");
    idle(); chk("R8 no strobe", pre_valid, 0);
    set_gate(1'b0); set_gate(1'b1);
    // 1,1,0 gives written ones 1,1,1: only the second and third are late
    put_bit(1, "run"); chk("R10 first one", late_shift, 0);
    put_bit(1, "run"); chk("R10 second one", late_shift, 1);
    put_bit(0, "run"); chk("R10 third one", {pre_bit, late_shift}, 2'b11);
  endtask

  task automatic t_collide;
    // Bad parity on the sixth marker: sync and error from the same edge.
    set_gate(1'b0); auto_train = 1'b1; scram_en = 1'b1; set_gate(1'b1);
    for (int i = 0; i < 5; i++) put_byte(8'hFF, 0);
    chk("R4 clean preamble", parity_err, 0);
    put_byte(8'hFF, 1);
    chk("R3 sync on bad byte", byte_out, 8'h69);
    chk("R4 set on sync edge", parity_err, 1);
    put_byte(8'hA5, 0); chk("R5 seed after collide", byte_out, 8'hA5 ^ ks_byte(0));
    // Gate falls with a valid code bit: preset wins.
    put_bit(1, "pre-drop"); put_bit(0, "pre-drop");
    @(negedge clk);
    wr_gate = 1'b0; code_valid = 1'b1; code_bit = 1'b1; byte_valid = 1'b0;
    y1 = 1'b0; y2 = 1'b0;
    @(posedge clk); #1;
    chk("R9 dropped bit", pre_valid, 0);
    chk("R9 dropped late", late_shift, 0);
    set_gate(1'b1);
    put_bit(1, "post-drop"); chk("R9 preset late", late_shift, 0);
    chk("R9 preset bit", pre_bit, 1);
  endtask

  initial begin
    for (int n = 0; n < 1024; n++) ks[n] = (n < 10) ? 1'b1 : (ks[n-7] ^ ks[n-10]);
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_auto();
    t_manual();
    t_parity();
    t_precode();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule